// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This block turns a system clock into CAN bit timing. A configuration word of six fields sets the clock divider, the sampling mode, the propagation segment, the two phase segments and the resynchronization jump width. The divided clock gives the time quantum. Each bit is built from four segments in this order: a sync segment of one quantum, then the propagation segment, then phase segment 1, then phase segment 2. The receive line is sampled at the end of phase segment 1. The sample is either a single read or a majority vote over three quanta.

Falling edges on the receive line keep the unit locked to the bus. While the bus is marked idle, a falling edge restarts the bit at once (hard synchronization). At other times, a falling edge moves the sample point and the bit end by the phase error, up to the jump width. A reserved zero code in either phase segment field stops the timing and raises an error flag. The block drives out a sampled bit, a sample strobe, and a transmit-point strobe that marks where the next transmit bit should be driven.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts `cfg_brp`+1 clock cycles, so codes 0 to 15 divide by 1 to 16.
- R2: With no edge on `rx_in`, a bit lasts 1 + (`cfg_prop`+1) + (`cfg_ph1`+1) + (`cfg_ph2`+1) quanta. `tx_stb` is high for exactly one cycle, in the first cycle of each sync segment, so the distance between strobes equals the bit length.
- R3: `sample_stb` is high for one cycle. It rises (1 + `cfg_prop`+1 + `cfg_ph1`+1) quanta after the preceding `tx_stb`, which places it at the end of phase segment 1, and it never coincides with `tx_stb`.
- R4: When `cfg_triple`=0, `rx_bit` takes the value of `rx_in` at the last clock of phase segment 1. It changes only in the cycle in which `sample_stb` is high. Logic 1 is recessive and logic 0 is dominant.
- R5: When `cfg_triple`=1, `rx_bit` is the majority of three values of `rx_in`: the one at the sample point, and the ones taken at the ends of the two quanta before it.
- R6: While `bus_idle`=0, a falling edge of `rx_in` in quantum k of the bit (sync is k=0) during the propagation segment or phase segment 1 lengthens phase segment 1 by min(k, `cfg_sjw`+1) quanta. This delays both the sample point and the bit end.
- R7: While `bus_idle`=0, a falling edge during phase segment 2 first finds r, the number of quanta left in that segment, counting the current one. If r ≤ `cfg_sjw`+1, the bit ends at once and the next sync segment starts, with `tx_stb` in the following cycle. Otherwise phase segment 2 is shortened by `cfg_sjw`+1 quanta.
- R8: A falling edge in the sync segment changes no timing. At most one edge per bit applies a correction.
- R9: While `bus_idle`=1, a falling edge of `rx_in` restarts the bit at the sync segment. `tx_stb` is high in the next cycle, and the bit that follows has the full configured length.
- R10: `cfg_err` is high exactly when `cfg_ph1` or `cfg_ph2` is 0. While it is high, the timing stays at the start of a sync segment and both strobes stay low. Once it clears, the first `tx_stb` follows one full bit later.
- R11: During reset, `rx_bit` is 1 and `sample_stb` and `tx_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_brp | input | BRP_W | Quantum divider code (divide by code+1) |
| cfg_triple | input | 1 | 1 selects three-sample majority |
| cfg_prop | input | SEG_W | Propagation segment length code (code+1 quanta) |
| cfg_ph1 | input | SEG_W | Phase segment 1 length code (code+1 quanta, 0 reserved) |
| cfg_ph2 | input | SEG_W | Phase segment 2 length code (code+1 quanta, 0 reserved) |
| cfg_sjw | input | SJW_W | Jump width code (code+1 quanta) |
| bus_idle | input | 1 | High while the bus is idle; selects hard synchronization |
| rx_in | input | 1 | Receive line, synchronous to clk |
| rx_bit | output | 1 | Sampled bit value |
| sample_stb | output | 1 | One-cycle pulse when rx_bit is updated |
| tx_stb | output | 1 | One-cycle pulse at the start of each sync segment |
| cfg_err | output | 1 | Reserved phase segment code present |

## Verification
The bench builds the unit with the default widths: a 4-bit divider code, 3-bit segment codes and a 2-bit jump width code. With these widths it can reach the largest divider of 16 and 8-quantum segments in all three segment fields within a few hundred cycles per bit. A divider of 4 with mid-range segments makes every quantum boundary a distinct clock edge. The bench can then place `rx_in` edges in chosen quanta and check phase corrections on both sides of the jump-width limit. It can also hold a glitch for exactly one tick to separate single from majority sampling.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 4,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] cfg_brp,
  input  logic             cfg_triple,
  input  logic [SEG_W-1:0] cfg_prop,
  input  logic [SEG_W-1:0] cfg_ph1,
  input  logic [SEG_W-1:0] cfg_ph2,
  input  logic [SJW_W-1:0] cfg_sjw,
  input  logic             bus_idle,
  input  logic             rx_in,
  output logic             rx_bit,
  output logic             sample_stb,
  output logic             tx_stb,
  output logic             cfg_err
);
  localparam int BW = SEG_W + 2;

  typedef enum logic [1:0] {SEG_SYNC, SEG_PROP, SEG_PH1, SEG_PH2} seg_t;

  seg_t             seg;
  logic [BRP_W-1:0] pcnt;
  logic [BW-1:0]    qcnt, bq, ext, cut;
  logic             done, prev_rx;
  logic [1:0]       hist;

  wire [BW-1:0] prop_q = BW'(cfg_prop);
  wire [BW-1:0] ph1_q  = BW'(cfg_ph1);
  wire [BW-1:0] ph2_q  = BW'(cfg_ph2);
  wire [BW-1:0] sjw_q  = BW'(cfg_sjw) + 1'b1;

  assign cfg_err = (cfg_ph1 == '0) | (cfg_ph2 == '0);

  wire tick   = (pcnt == cfg_brp);
  wire fall   = prev_rx & ~rx_in;
  wire hard   = bus_idle & fall;
  wire resync = ~bus_idle & fall & ~done;
  wire late   = resync & ((seg == SEG_PROP) | (seg == SEG_PH1));
  wire early  = resync & (seg == SEG_PH2);

  wire [BW-1:0] rem       = ph2_q + 1'b1 - qcnt;
  wire          early_now = early & (rem <= sjw_q);
  wire [BW-1:0] ext_n     = late ? ((bq < sjw_q) ? bq : sjw_q) : ext;
  wire [BW-1:0] cut_n     = (early & ~early_now) ? sjw_q : cut;

  wire vote = cfg_triple ? ((rx_in & hist[0]) | (rx_in & hist[1]) | (hist[0] & hist[1]))
                         : rx_in;

  wire seg_end = (seg == SEG_SYNC) |
                 ((seg == SEG_PROP) & (qcnt == prop_q)) |
                 ((seg == SEG_PH1)  & (qcnt == ph1_q + ext_n)) |
                 ((seg == SEG_PH2)  & (qcnt == ph2_q - cut_n));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg        <= SEG_SYNC;
      pcnt       <= '0;
      qcnt       <= '0;
      bq         <= '0;
      ext        <= '0;
      cut        <= '0;
      done       <= 1'b0;
      prev_rx    <= 1'b1;
      hist       <= 2'b11;
      rx_bit     <= 1'b1;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
    end else begin
      prev_rx    <= rx_in;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
      if (cfg_err) begin
        seg  <= SEG_SYNC;
        pcnt <= '0;
        qcnt <= '0;
        bq   <= '0;
        ext  <= '0;
        cut  <= '0;
        done <= 1'b0;
      end else if (hard | early_now) begin
        seg    <= SEG_SYNC;
        pcnt   <= '0;
        qcnt   <= '0;
        bq     <= '0;
        ext    <= '0;
        cut    <= '0;
        done   <= 1'b1;
        tx_stb <= 1'b1;
      end else begin
        if (fall & ~bus_idle) done <= 1'b1;
        ext  <= ext_n;
        cut  <= cut_n;
        pcnt <= tick ? '0 : pcnt + 1'b1;
        if (tick) begin
          hist <= {hist[0], rx_in};
          bq   <= bq + 1'b1;
          if (seg_end) begin
            qcnt <= '0;
            case (seg)
              SEG_SYNC: seg <= SEG_PROP;
              SEG_PROP: seg <= SEG_PH1;
              SEG_PH1: begin
                seg        <= SEG_PH2;
                sample_stb <= 1'b1;
                rx_bit     <= vote;
              end
              SEG_PH2: begin
                seg    <= SEG_SYNC;
                tx_stb <= 1'b1;
                bq     <= '0;
                ext    <= '0;
                cut    <= '0;
                done   <= 1'b0;
              end
            endcase
          end else begin
            qcnt <= qcnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_err,
  input logic rx_bit,
  input logic sample_stb,
  input logic tx_stb
);
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> (!sample_stb && !tx_stb));

  assert_tx_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |=> !tx_stb);

  assert_sample_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && tx_stb));

  assert_bit_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(rx_bit));
endmodule

bind can_bit_timer can_bit_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_err(cfg_err), .rx_bit(rx_bit),
  .sample_stb(sample_stb), .tx_stb(tx_stb)
);

// File: tb/can_bit_timer_tb_top.sv
module can_bit_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_brp = 4'd3;
  logic       cfg_triple = 1'b0;
  logic [2:0] cfg_prop = 3'd2, cfg_ph1 = 3'd3, cfg_ph2 = 3'd4;
  logic [1:0] cfg_sjw = 2'd1;
  logic       bus_idle = 1'b0;
  logic       rx_in = 1'b1;
  logic       rx_bit, sample_stb, tx_stb, cfg_err;
  int         checks = 0, fails = 0;

  always #10 clk = ~clk;

  can_bit_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_triple(cfg_triple),
    .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw),
    .bus_idle(bus_idle), .rx_in(rx_in), .rx_bit(rx_bit), .sample_stb(sample_stb),
    .tx_stb(tx_stb), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg(input logic [3:0] brp, input logic trip, input logic [2:0] prop,
                           input logic [2:0] p1, input logic [2:0] p2, input logic [1:0] sjw);
    @(negedge clk);
    rst_n = 1'b0; rx_in = 1'b1; bus_idle = 1'b0;
    cfg_brp = brp; cfg_triple = trip; cfg_prop = prop;
    cfg_ph1 = p1; cfg_ph2 = p2; cfg_sjw = sjw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_tx();
    int n = 0;
    while (!tx_stb && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic probe(input int fall_at, output int ts, output int tb);
    wait_tx();
    ts = -1; tb = -1;
    if (fall_at == 1) rx_in = 1'b0;
    for (int k = 2; k < 3000; k++) begin
      @(negedge clk);
      if (sample_stb && ts < 0) ts = k - 1;
      if (tx_stb) begin
        tb = k - 1;
        break;
      end
      if (k == fall_at) rx_in = 1'b0;
    end
  endtask

  task automatic t_reset_R11();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 rx_bit", rx_bit, 1);
    chk("R11 sample_stb", sample_stb, 0);
    chk("R11 tx_stb", tx_stb, 0);
    chk("R10 cfg_err valid cfg", cfg_err, 0);
  endtask

  task automatic t_timing(input logic [3:0] brp, input logic [2:0] prop, input logic [2:0] p1,
                          input logic [2:0] p2);
    int ts, tb, q, s, n;
    q = int'(brp) + 1;
    s = 1 + int'(prop) + 1 + int'(p1) + 1;
    n = s + int'(p2) + 1;
    apply_cfg(brp, 1'b0, prop, p1, p2, 2'd0);
    probe(0, ts, tb);
    chk("R1 R2 bit length", tb, n * q);
    chk("R3 sample position", ts, s * q);
  endtask

  task automatic t_sampling(input logic trip, input logic [2:0] pat, input logic exp,
                            input string req);
    int ts = -1;
    int got = -1;
    apply_cfg(4'd3, trip, 3'd2, 3'd3, 3'd4, 2'd1);
    wait_tx();
    rx_in = 1'b0;
    for (int k = 2; k < 200; k++) begin
      @(negedge clk);
      if (sample_stb) begin
        ts = k - 1;
        got = int'(rx_bit);
        break;
      end
      rx_in = (k == 24) ? pat[2] : (k == 28) ? pat[1] : (k == 32) ? pat[0] : 1'b1;
    end
    rx_in = 1'b1;
    chk(req, got, int'(exp));
    chk("R8 sync edge keeps sample point", ts, 32);
  endtask

  task automatic t_late_R6(input logic [1:0] sjw, input int quantum, input int extq);
    int ts, tb;
    apply_cfg(4'd3, 1'b0, 3'd2, 3'd3, 3'd4, sjw);
    probe(quantum * 4 + 1, ts, tb);
    chk("R6 late edge sample", ts, (8 + extq) * 4);
    chk("R6 late edge bit", tb, (13 + extq) * 4);
  endtask

  task automatic t_early_R7(input logic [1:0] sjw, input int quantum, input int exp_tb);
    int ts, tb;
    apply_cfg(4'd3, 1'b0, 3'd2, 3'd3, 3'd4, sjw);
    probe(quantum * 4 + 1, ts, tb);
    chk("R7 early edge bit end", tb, exp_tb);
  endtask

  task automatic t_sync_edge_R8();
    int ts, tb;
    apply_cfg(4'd3, 1'b0, 3'd2, 3'd3, 3'd4, 2'd3);
    probe(1, ts, tb);
    chk("R8 sync edge bit length", tb, 52);
    chk("R8 sync edge sample", ts, 32);
  endtask

  task automatic t_hard_R9();
    int ts, tb;
    apply_cfg(4'd3, 1'b0, 3'd2, 3'd3, 3'd4, 2'd1);
    bus_idle = 1'b1;
    probe(10, ts, tb);
    chk("R9 hard sync restart", tb, 10);
    probe(0, ts, tb);
    chk("R9 full bit after hard sync", tb, 52);
    chk("R9 sample after hard sync", ts, 32);
    bus_idle = 1'b0;
  endtask

  task automatic t_cfg_err_R10();
    int strobes = 0;
    int first = -1;
    apply_cfg(4'd3, 1'b0, 3'd2, 3'd0, 3'd4, 2'd1);
    #1 chk("R10 ph1 zero flag", cfg_err, 1);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (sample_stb || tx_stb) strobes++;
    end
    chk("R10 no strobes ph1 zero", strobes, 0);
    cfg_ph1 = 3'd3; cfg_ph2 = 3'd0;
    #1 chk("R10 ph2 zero flag", cfg_err, 1);
    strobes = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (sample_stb || tx_stb) strobes++;
    end
    chk("R10 no strobes ph2 zero", strobes, 0);
    cfg_ph2 = 3'd4;
    #1 chk("R10 flag clears", cfg_err, 0);
    for (int k = 1; k < 500; k++) begin
      @(negedge clk);
      if (tx_stb) begin
        first = k;
        break;
      end
    end
    chk("R10 first bit after clear", first, 52);
  endtask

  initial begin
    t_reset_R11();
    t_timing(4'd0, 3'd0, 3'd1, 3'd1);
    t_timing(4'd3, 3'd2, 3'd3, 3'd4);
    t_timing(4'd15, 3'd7, 3'd7, 3'd7);
    t_sampling(1'b0, 3'b110, 1'b0, "R4 single sample dominant glitch");
    t_sampling(1'b0, 3'b001, 1'b1, "R4 single sample recessive point");
    t_sampling(1'b1, 3'b110, 1'b1, "R5 majority rejects glitch");
    t_sampling(1'b1, 3'b001, 1'b0, "R5 majority two dominant");
    t_sampling(1'b1, 3'b000, 1'b0, "R5 majority all dominant");
    t_late_R6(2'd1, 1, 1);
    t_late_R6(2'd1, 3, 2);
    t_late_R6(2'd3, 3, 3);
    t_late_R6(2'd3, 5, 4);
    t_early_R7(2'd1, 9, 44);
    t_early_R7(2'd1, 11, 45);
    t_early_R7(2'd0, 9, 48);
    t_sync_edge_R8();
    t_hard_R9();
    t_cfg_err_R10();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule